// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic read and write an external asynchronous static RAM of 128K words by 16 bits. The host raises a request together with a write flag, a word address, write data and a two-bit byte mask. The controller latches these values and runs one complete memory cycle. It then pulses `done` for a single clock. On a read, the data captured from the memory is on `rdata` while `done` is high.

Each phase of a memory cycle lasts a fixed number of system clocks, set by parameters. The defaults assume a 10 ns clock and meet the fastest speed grade of such parts.

- A read holds the address, chip enable, output enable and both byte enables for six clocks, then samples the data.
- A write holds the chip enable and the selected byte enables for six clocks. Write enable is low in clocks two to five. The write ends when write enable rises, and data and address are still held for one more clock after that edge.
- The data bus is split into an output, an input and an output enable. The controller drives the bus only during writes.
- An idle clock always separates the end of one access from the start of the next, so the controller and the memory never drive the bus at the same time.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n and mem_lb_n are all high, mem_dout_en is low and done is low.
- R2: A read keeps mem_ce_n, mem_oe_n, mem_ub_n and mem_lb_n low for exactly 6 clocks. During those clocks the address stays stable, mem_we_n stays high and mem_dout_en stays low.
- R3: A read captures mem_din at the end of its sixth clock and shows that value on rdata while done is high.
- R4: A write keeps mem_ce_n low for 6 clocks. mem_we_n is low for exactly 4 clocks, starting in the second, and mem_oe_n stays high throughout.
- R5: During all 6 clocks of a write, mem_addr equals the requested address and mem_dout equals the requested data with mem_dout_en high. This includes the clock after mem_we_n rises.
- R6: In a write, host mask bit 0 enables the lower byte lane (mem_lb_n low) and bit 1 enables the upper lane (mem_ub_n low). A lane whose bit is 0 stays disabled and its byte in memory is unchanged. A mask of 00 changes no byte.
- R7: A request is taken only in the idle state. done is high for exactly one clock, the seventh clock after the request is taken. A request held or changed during an access starts nothing and does not alter the running access.
- R8: mem_dout_en is never high while mem_oe_n is low. mem_oe_n never goes low in the clock directly after mem_dout_en was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, sampled when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Word address |
| wdata | input | 16 | Write data |
| bmask | input | 2 | Byte lanes to write: bit 0 lower, bit 1 upper |
| rdata | output | 16 | Read data, valid while done is high |
| done | output | 1 | One-clock pulse at the end of an access |
| mem_addr | output | 17 | Memory address |
| mem_dout | output | 16 | Data toward the memory |
| mem_din | input | 16 | Data from the memory |
| mem_dout_en | output | 1 | Enable for the data bus drivers |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte enable, active low |
| mem_lb_n | output | 1 | Lower byte enable, active low |

## Verification
The bench runs accesses against a behavioural memory model, which commits bytes on the rising edge of write enable. It tries full-word writes and reads, and a read-back after each of the mask values 01, 10 and 00. These separate swapped or merged lane strobes from correct lane selection. A word at a high address shows whether all 17 address bits reach the pins. A request that is held and altered during an access shows whether a busy controller ignores it. A write followed directly by a read shows whether the bus turnaround gap is present.

// File: rtl/sram_ctl.sv
module sram_ctl #(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 16,
  parameter int ACC_CYC  = 6,
  parameter int WE_FIRST = 1,
  parameter int WE_LAST  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        bmask,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dout,
  input  logic [DATA_W-1:0] mem_din,
  output logic              mem_dout_en,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n
);
  localparam int CNT_W = $clog2(ACC_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACC_CYC - 1);
  localparam logic [CNT_W-1:0] WON  = CNT_W'(WE_FIRST);
  localparam logic [CNT_W-1:0] WOFF = CNT_W'(WE_LAST);

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_DONE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic              is_wr;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] d_q;
  logic [1:0]        m_q;
  logic              in_acc;
  logic [1:0]        lanes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      a_q   <= '0;
      d_q   <= '0;
      m_q   <= '0;
      rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (req) begin
          st    <= S_ACC;
          cnt   <= '0;
          is_wr <= wr;
          a_q   <= addr;
          d_q   <= wdata;
          m_q   <= bmask;
        end
        S_ACC: if (cnt == LAST) begin
          st <= S_DONE;
          if (!is_wr) rdata <= mem_din;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_acc      = (st == S_ACC);
  assign lanes       = in_acc ? (is_wr ? m_q : 2'b11) : 2'b00;
  assign done        = (st == S_DONE);
  assign mem_addr    = a_q;
  assign mem_dout    = d_q;
  assign mem_dout_en = in_acc && is_wr;
  assign mem_ce_n    = !in_acc;
  assign mem_oe_n    = !(in_acc && !is_wr);
  assign mem_we_n    = !(in_acc && is_wr && cnt >= WON && cnt <= WOFF);
  assign mem_lb_n    = !lanes[0];
  assign mem_ub_n    = !lanes[1];
endmodule

module sram_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic [16:0] mem_addr,
  input logic [15:0] mem_dout,
  input logic        mem_dout_en,
  input logic        mem_ce_n,
  input logic        mem_oe_n,
  input logic        mem_we_n,
  input logic        mem_ub_n,
  input logic        mem_lb_n
);
  assert_no_bus_fight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dout_en && !mem_oe_n));
  assert_turnaround_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> !$past(mem_dout_en));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_read_lanes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && !mem_ub_n && !mem_lb_n && mem_we_n));
  assert_we_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dout_en));
  assert_we_end_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_we_n) && !mem_ce_n) |-> (mem_dout_en && $stable(mem_addr) && $stable(mem_dout)));
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
endmodule

bind sram_ctl sram_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_addr(mem_addr), .mem_dout(mem_dout),
  .mem_dout_en(mem_dout_en), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
);

// File: tb/test_sram_ctl.sv
module test_sram_ctl;
  localparam time CLK_P = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  bmask = '0;
  logic [15:0] rdata, mem_dout, mem_din;
  logic [16:0] mem_addr;
  logic done, mem_dout_en, mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

  sram_ctl i_sram_ctl (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .bmask(bmask), .rdata(rdata), .done(done), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_din(mem_din), .mem_dout_en(mem_dout_en),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n)
  );

  always #(CLK_P/2) clk = ~clk;

  logic [15:0] mem [0:255];
  assign mem_din = (!mem_ce_n && !mem_oe_n) ? mem[mem_addr[7:0]] : 16'hBAD0;
  always @(posedge mem_we_n) if (mem_ce_n === 1'b0) begin
    if (mem_lb_n === 1'b0) mem[mem_addr[7:0]][7:0]  <= mem_dout[7:0];
    if (mem_ub_n === 1'b0) mem[mem_addr[7:0]][15:8] <= mem_dout[15:8];
  end

  int n_cmp = 0, n_bad = 0;
  int g_cyc, g_ce, g_oe, g_we, g_wefirst, g_lb, g_ub, g_abad, g_dbad, g_hold;
  int n_fight = 0, n_turn = 0;
  logic prev_en = 1'b0;
  logic [15:0] g_rd;

  always @(negedge clk) begin
    if (mem_dout_en === 1'b1 && mem_oe_n === 1'b0) n_fight++;
    if (mem_oe_n === 1'b0 && prev_en) n_turn++;
    prev_en = (mem_dout_en === 1'b1);
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic w, input logic [16:0] a, input logic [15:0] d,
                     input logic [1:0] m, input bit stray);
    int n;
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; bmask = m;
    @(posedge clk);
    @(negedge clk);
    if (!stray) req = 1'b0;
    else begin addr = a ^ 17'h00155; wdata = ~d; wr = ~w; end
    g_ce = 0; g_oe = 0; g_we = 0; g_wefirst = 0; g_lb = 0; g_ub = 0;
    g_abad = 0; g_dbad = 0; g_hold = 0;
    n = 1;
    while (done !== 1'b1 && n < 20) begin
      if (!mem_ce_n) g_ce++;
      if (!mem_oe_n) g_oe++;
      if (!mem_lb_n) g_lb++;
      if (!mem_ub_n) g_ub++;
      if (!mem_we_n) begin g_we++; if (g_wefirst == 0) g_wefirst = n; end
      if (!mem_ce_n && mem_addr !== a) g_abad++;
      if (w && !mem_ce_n && (mem_dout !== d || mem_dout_en !== 1'b1)) g_dbad++;
      if (w && n == 6 && mem_we_n && mem_dout_en && mem_dout === d && mem_addr === a) g_hold = 1;
      @(negedge clk);
      n++;
    end
    g_cyc = n;
    g_rd = rdata;
    req = 1'b0;
  endtask

  task automatic t_reset;
    repeat (2) @(negedge clk);
    chk("R1 strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}, 5'b11111);
    chk("R1 bus/done", {mem_dout_en, done}, 2'b00);
    rst_n = 1'b1;
  endtask

  task automatic t_word;
    run(1'b1, 17'h000A5, 16'h1234, 2'b11, 1'b0);
    chk("R7 write latency", g_cyc, 7);
    chk("R4 ce clocks", g_ce, 6);
    chk("R4 we clocks", g_we, 4);
    chk("R4 we start", g_wefirst, 2);
    chk("R4 oe high", g_oe, 0);
    chk("R5 addr/data", g_abad + g_dbad, 0);
    chk("R5 hold after we", g_hold, 1);
    run(1'b0, 17'h000A5, 16'h0, 2'b00, 1'b0);
    chk("R2 oe clocks", g_oe, 6);
    chk("R2 lanes", {g_lb[7:0], g_ub[7:0]}, {8'd6, 8'd6});
    chk("R2 we high", g_we, 0);
    chk("R3 rdata", g_rd, 16'h1234);
    chk("R7 read latency", g_cyc, 7);
  endtask

  task automatic t_lanes;
    run(1'b1, 17'h00010, 16'h5566, 2'b01, 1'b0);
    chk("R6 lower only", {g_lb[7:0], g_ub[7:0]}, {8'd6, 8'd0});
    run(1'b0, 17'h00010, 16'h0, 2'b00, 1'b0);
    chk("R6 readback 01", g_rd, 16'hAA66);
    run(1'b1, 17'h00010, 16'h7788, 2'b10, 1'b0);
    chk("R6 upper only", {g_lb[7:0], g_ub[7:0]}, {8'd0, 8'd6});
    run(1'b0, 17'h00010, 16'h0, 2'b00, 1'b0);
    chk("R6 readback 10", g_rd, 16'h7766);
    run(1'b1, 17'h00010, 16'h0000, 2'b00, 1'b0);
    chk("R6 no lanes", g_lb + g_ub, 0);
    run(1'b0, 17'h00010, 16'h0, 2'b00, 1'b0);
    chk("R6 readback 00", g_rd, 16'h7766);
  endtask

  task automatic t_high;
    run(1'b1, 17'h1ABCD, 16'hC0DE, 2'b11, 1'b0);
    chk("R5 high addr write", g_abad, 0);
    run(1'b0, 17'h1ABCD, 16'h0, 2'b00, 1'b0);
    chk("R2 high addr read", g_abad, 0);
    chk("R3 high rdata", g_rd, 16'hC0DE);
  endtask

  task automatic t_stray;
    int busy;
    run(1'b0, 17'h00033, 16'h0, 2'b00, 1'b1);
    chk("R7 stray addr", g_abad, 0);
    chk("R7 stray latency", g_cyc, 7);
    chk("R7 stray oe", g_oe, 6);
    busy = 0;
    repeat (4) begin @(negedge clk); if (!mem_ce_n || done) busy++; end
    chk("R7 no extra access", busy, 0);
  endtask

  task automatic t_turn;
    run(1'b1, 17'h00040, 16'h4242, 2'b11, 1'b0);
    run(1'b0, 17'h00040, 16'h0, 2'b00, 1'b0);
    chk("R3 turn rdata", g_rd, 16'h4242);
    chk("R8 bus fight", n_fight, 0);
    chk("R8 turnaround gap", n_turn, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hAAAA;
    t_reset();
    t_word();
    t_lanes();
    t_high();
    t_stray();
    t_turn();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule